// File: doc/BRIEF.md
# I2C Slave Address Recognition and Status Flags

This block sits beside an I2C shift engine. It decides whether the first byte received after a START condition (a repeated START included) selects this device as a slave, and it holds the flags that report the result. It has a registered address-match flag and a separate general-call flag. It also drives a status byte. The low half of the status byte carries the flags and is read-only. The high half is a small control nibble that software may write.

The block can compare addresses in two ways. In 7-bit addressing it compares the upper seven bits of the received byte with the upper seven bits of the own-address register; bit 0 is the read/write direction and takes no part. In 10-bit addressing it compares the whole first byte, direction bit included, with all eight bits of the register. A free-data-format select turns address comparison off completely. Matching of the second 10-bit byte and driving of ACK are handled elsewhere.

Each flag has its own clearing event. The general-call flag clears on START or STOP. The address-match flag clears when software writes the data shift register.

Top module: `slv_addr_match`

## Requirements
- R1: After synchronous reset, `addr_match_o`, `gen_call_o` and all eight bits of `status_o` are 0.
- R2: In 7-bit mode (`ten_bit_i`=0), with slave mode on and addressing format selected, a first byte whose bits [7:1] equal `own_addr_i[7:1]` sets `addr_match_o` in the cycle after `byte_done_i`. Bit 0 of the byte is ignored.
- R3: With slave mode on and addressing format selected, a first byte of 0x00 sets `gen_call_o` one cycle after `byte_done_i`. In 7-bit mode it also sets `addr_match_o`.
- R4: In 10-bit mode (`ten_bit_i`=1), `addr_match_o` sets only when all 8 bits of the first byte equal `own_addr_i`.
- R5: A pulse on `start_det_i` arms the block for exactly one byte. That byte is compared, and the block is disarmed by the next `byte_done_i` or by `stop_det_i`. Bytes received while the block is not armed never set either flag.
- R6: When `free_fmt_i`=1 or `slave_mode_i`=0, a received byte sets neither flag.
- R7: `gen_call_o` clears one cycle after `start_det_i` or `stop_det_i`. A STOP in the same cycle as a general-call byte leaves the flag at 0.
- R8: A pulse on `dsr_wr_i` clears `addr_match_o` in the next cycle. If a match is detected in the same cycle as the write, the match wins and the flag reads 1.
- R9: `status_o` bit 0 is the general-call flag, bit 1 is the address-match flag, bit 2 is 1 while the block is armed, and bit 3 is always 0. Bits [7:4] hold the value last written via `ctl_wr_i`/`ctl_wdata_i`; such writes leave bits [3:0] unchanged.
- R10: If `start_det_i` and `byte_done_i` arrive in the same cycle, that byte is not compared, and the block is armed for the following byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_i | input | 8 | Byte from the shift engine, valid with `byte_done_i` |
| byte_done_i | input | 1 | One-cycle strobe: a byte has been received |
| start_det_i | input | 1 | One-cycle START / repeated START detect |
| stop_det_i | input | 1 | One-cycle STOP detect |
| own_addr_i | input | 8 | Own-address register contents |
| ten_bit_i | input | 1 | 0: 7-bit addressing, 1: 10-bit addressing |
| free_fmt_i | input | 1 | 0: addressing format, 1: free data format |
| slave_mode_i | input | 1 | 1 when the interface operates as a slave |
| dsr_wr_i | input | 1 | Strobe: software wrote the data shift register |
| ctl_wr_i | input | 1 | Strobe: write the control nibble of the status byte |
| ctl_wdata_i | input | 4 | New control nibble value |
| addr_match_o | output | 1 | Address-match flag |
| gen_call_o | output | 1 | General-call flag |
| status_o | output | 8 | Status byte for software reads |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a matching first byte and a data-shift-register write, which set and clear the address-match flag together. The second pair is a general-call byte and a STOP, which set and clear the general-call flag together. Directed steps place each pair exactly on one clock edge and then check that the match flag reads 1 and the general-call flag reads 0. START together with `byte_done_i` is forced in the same way; the bench checks that the block stays armed and that no flag is set. A seeded random phase raises these coincidences again among mixed traffic, and a reference model in the bench judges every cycle.

// File: rtl/slv_addr_pkg.sv
package slv_addr_pkg;

    typedef enum logic {
        ADDR_7BIT  = 1'b0,
        ADDR_10BIT = 1'b1
    } addr_mode_e;

    typedef struct packed {
        logic [3:0] ctl;
        logic       rsvd;
        logic       armed;
        logic       match;
        logic       gcall;
    } status_t;

    typedef struct packed {
        logic hit;
        logic gcall;
    } cmp_res_t;

    function automatic addr_mode_e to_mode(input logic sel);
        return sel ? ADDR_10BIT : ADDR_7BIT;
    endfunction

endpackage

// File: rtl/sam_cmp.sv
module sam_cmp
    import slv_addr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] own_addr,
    input  addr_mode_e        mode,
    output cmp_res_t          res
);
    localparam int DIR_LSB = 1;

    logic is_zero;
    logic hit7;
    logic hit10;

    always_comb begin
        is_zero = (rx_byte == '0);
        hit7    = (rx_byte[DATA_W-1:DIR_LSB] == own_addr[DATA_W-1:DIR_LSB]) || is_zero;
        hit10   = (rx_byte == own_addr);
        res.gcall = is_zero;
        res.hit   = (mode == ADDR_10BIT) ? hit10 : hit7;
    end
endmodule

// File: rtl/sam_flag.sv
module sam_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d;

    generate
        if (SET_WINS) begin : g_set_first
            always_comb q_d = set_i ? 1'b1 : (clr_i ? 1'b0 : q_o);
        end else begin : g_clr_first
            always_comb q_d = clr_i ? 1'b0 : (set_i ? 1'b1 : q_o);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= q_d;
    end
endmodule

// File: rtl/slv_addr_match.sv
module slv_addr_match
    import slv_addr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              byte_done_i,
    input  logic              start_det_i,
    input  logic              stop_det_i,
    input  logic [DATA_W-1:0] own_addr_i,
    input  logic              ten_bit_i,
    input  logic              free_fmt_i,
    input  logic              slave_mode_i,
    input  logic              dsr_wr_i,
    input  logic              ctl_wr_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    output logic              addr_match_o,
    output logic              gen_call_o,
    output logic [DATA_W-1:0] status_o
);
    logic             armed_q;
    logic [CTL_W-1:0] ctl_q;
    logic             eval;
    cmp_res_t         cmp;
    status_t          st;

    sam_cmp #(.DATA_W(DATA_W)) u_cmp (
        .rx_byte  (rx_byte_i),
        .own_addr (own_addr_i),
        .mode     (to_mode(ten_bit_i)),
        .res      (cmp)
    );

    // Only the first byte of an armed window is judged; START in the same cycle discards it
    assign eval = byte_done_i && armed_q && !start_det_i && slave_mode_i && !free_fmt_i;

    always_ff @(posedge clk) begin
        if (rst)                            armed_q <= 1'b0;
        else if (start_det_i)               armed_q <= 1'b1;
        else if (stop_det_i || byte_done_i) armed_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)           ctl_q <= '0;
        else if (ctl_wr_i) ctl_q <= ctl_wdata_i;
    end

    sam_flag #(.SET_WINS(1'b0)) u_gcall (
        .clk   (clk),
        .rst   (rst),
        .set_i (eval && cmp.gcall),
        .clr_i (start_det_i || stop_det_i),
        .q_o   (gen_call_o)
    );

    sam_flag #(.SET_WINS(1'b1)) u_match (
        .clk   (clk),
        .rst   (rst),
        .set_i (eval && cmp.hit),
        .clr_i (dsr_wr_i),
        .q_o   (addr_match_o)
    );

    always_comb begin
        st.ctl   = ctl_q;
        st.rsvd  = 1'b0;
        st.armed = armed_q;
        st.match = addr_match_o;
        st.gcall = gen_call_o;
        status_o = st;
    end

    assert_gc_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (start_det_i || stop_det_i) |=> !gen_call_o);

    assert_match_src_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_match_o) |-> $past(byte_done_i && armed_q && !start_det_i));

    assert_gc_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_call_o) |-> ($past(rx_byte_i) == '0));

    assert_no_set_R6: assert property (@(posedge clk) disable iff (rst)
        (free_fmt_i || !slave_mode_i) |=> !$rose(addr_match_o) && !$rose(gen_call_o));

    assert_wr_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (dsr_wr_i && !byte_done_i) |=> !addr_match_o);

    assert_arm_R10: assert property (@(posedge clk) disable iff (rst)
        start_det_i |=> armed_q);
endmodule

// File: tb/slv_addr_match_bench.sv
`timescale 1ns/1ps
module slv_addr_match_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx = '0, own = '0;
    logic       bd = 0, s = 0, p = 0, ten = 0, ff = 0, sm = 1, dw = 0, cw = 0;
    logic [3:0] cd = '0;
    logic       match_o, gc_o;
    logic [7:0] st_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_gc, m_match, m_arm;
    logic [3:0] m_ctl;

    always #2.5 clk = ~clk;

    slv_addr_match u_slv_addr_match (
        .clk(clk), .rst(rst), .rx_byte_i(rx), .byte_done_i(bd),
        .start_det_i(s), .stop_det_i(p), .own_addr_i(own), .ten_bit_i(ten),
        .free_fmt_i(ff), .slave_mode_i(sm), .dsr_wr_i(dw), .ctl_wr_i(cw),
        .ctl_wdata_i(cd), .addr_match_o(match_o), .gen_call_o(gc_o), .status_o(st_o)
    );

    function automatic bit ref_hit(input logic [7:0] b, input logic [7:0] a, input bit t);
        if (t) return b == a;
        return (b[7:1] == a[7:1]) || (b == 8'h00);
    endfunction

    function automatic logic [7:0] ref_status();
        return {m_ctl, 1'b0, m_arm, m_match, m_gc};
    endfunction

    task automatic model_step();
        bit ev;
        ev = bd && m_arm && !s && sm && !ff;
        if (s || p) m_gc = 0;
        else if (ev && rx == 8'h00) m_gc = 1;
        if (ev && ref_hit(rx, own, ten)) m_match = 1;
        else if (dw) m_match = 0;
        if (s) m_arm = 1;
        else if (p || bd) m_arm = 0;
        if (cw) m_ctl = cd;
        if (rst) begin m_gc = 0; m_match = 0; m_arm = 0; m_ctl = '0; end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        bd = 0; s = 0; p = 0; dw = 0; cw = 0;
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic rx_byte(input logic [7:0] b);
        rx = b; bd = 1; tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 0;
        check("R1 reset status", st_o, 8'h00);
        check("R1 reset flags", {6'b0, match_o, gc_o}, 8'h00);

        own = 8'hA4; ten = 0;
        cw = 1; cd = 4'h5; tick();
        check("R9 ctl nibble write", st_o, 8'h50);

        s = 1; tick();
        check("R9 armed bit", st_o, 8'h54);
        rx_byte(8'hA5);
        check("R2 7-bit match ignores bit0", st_o, 8'h52);

        dw = 1; tick();
        check("R8 dsr write clears match", {7'b0, match_o}, 8'h00);
        rx_byte(8'hA4);
        check("R5 unarmed byte ignored", st_o, 8'h50);

        s = 1; tick();
        rx_byte(8'h00);
        check("R3 general call 7-bit", st_o, 8'h53);
        p = 1; tick();
        check("R7 stop clears gcall only", st_o, 8'h52);

        s = 1; tick();
        rx = 8'hA4; bd = 1; dw = 1; tick();
        check("R8 match wins over dsr write", {7'b0, match_o}, 8'h01);
        dw = 1; tick();

        s = 1; tick();
        rx = 8'h00; bd = 1; p = 1; tick();
        check("R7 stop beats gcall set", {6'b0, match_o, gc_o}, 8'h02);
        dw = 1; tick();

        s = 1; tick();
        rx_byte(8'h00);
        s = 1; tick();
        check("R7 start clears gcall", {7'b0, gc_o}, 8'h00);

        own = 8'hF2; ten = 1; dw = 1; tick();
        rx_byte(8'hF3);
        check("R4 10-bit rw bit mismatch", {7'b0, match_o}, 8'h00);
        s = 1; tick();
        rx_byte(8'hF2);
        check("R4 10-bit full match", {7'b0, match_o}, 8'h01);
        s = 1; dw = 1; tick();
        rx_byte(8'h00);
        check("R4 10-bit zero byte no match", {6'b0, match_o, gc_o}, 8'h01);

        ten = 0; own = 8'h3C; dw = 1; s = 1; tick();
        ff = 1; rx_byte(8'h3C);
        check("R6 free format no compare", st_o & 8'h0F, 8'h00);
        ff = 0; sm = 0; s = 1; tick();
        rx_byte(8'h00);
        check("R6 not slave no flags", st_o & 8'h0F, 8'h00);
        sm = 1;

        s = 1; tick();
        s = 1; rx = 8'h3C; bd = 1; tick();
        check("R10 start with byte_done", st_o & 8'h0F, 8'h04);
        rx_byte(8'h3D);
        check("R10 next byte compared", st_o & 8'h0F, 8'h02);

        m_gc = gc_o; m_match = match_o; m_arm = st_o[2]; m_ctl = st_o[7:4];
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            own = ($urandom % 8 == 0) ? 8'h00 : own;
            if ($urandom % 50 == 0) own = 8'($urandom);
            ten = ($urandom % 4 == 0);
            ff  = ($urandom % 10 == 0);
            sm  = ($urandom % 10 != 0);
            case ($urandom % 4)
                0: rx = own;
                1: rx = own ^ 8'h01;
                2: rx = 8'h00;
                default: rx = 8'($urandom);
            endcase
            bd = ($urandom % 3 == 0);
            s  = ($urandom % 5 == 0);
            p  = ($urandom % 8 == 0);
            dw = ($urandom % 6 == 0);
            cw = ($urandom % 10 == 0);
            cd = 4'($urandom);
            tick();
            check("R9 random status vs model", st_o, ref_status());
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule